// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block sits beside the execute stage of a processor that supports user, supervisor and machine privilege and an optional hypervisor. The decoder sends it four kinds of system instruction: wait-for-interrupt and three address-translation fences. These are the supervisor fence and the two hypervisor fences, one for guest virtual addresses and one for guest physical addresses. For each request the block checks the current privilege, the virtualization state, which extensions are present and four trap-control bits. It then decides whether the instruction may go ahead or must raise an exception.

A request is a single-cycle pulse on `req_valid`. On the next cycle the block gives exactly one of three one-cycle strobes. `halt_req` asks the core to stall for an interrupt. `flush_req` asks the translation cache to be flushed. `exc_valid` raises an exception, and its cause code is on `exc_cause`. The translation cache itself, the stall logic and the wake-up logic are outside this block.

Top module: `priv_trap_gate`

## Requirements
- R1: A wait-for-interrupt request (op 0) raises illegal-instruction (cause 2) when `tw_bit` is 1 and either the privilege is supervisor (1) or the privilege is user (0) with `has_smode` at 0. This applies whether or not the core is virtualized.
- R2: A wait-for-interrupt request in user mode (0), with `virt_on` at 0 and `has_smode` at 1, raises illegal-instruction (cause 2).
- R3: A wait-for-interrupt request with `virt_on` at 1 raises virtual-instruction (cause 22) when the privilege is user (0), or when it is supervisor (1) with `vtw_bit` at 1. This rule applies only when neither R1 nor R2 applies.
- R4: A wait-for-interrupt request that meets none of R1 to R3 asserts `halt_req`.
- R5: A supervisor fence (op 1) raises illegal-instruction (cause 2) in user mode, or in supervisor mode with `tvm_bit` at 1. Otherwise, if `has_hyp`, `virt_on` and `vtvm_bit` are all 1, it raises virtual-instruction (cause 22). Otherwise it asserts `flush_req`.
- R6: A hypervisor fence (op 2 for guest virtual, op 3 for guest physical) raises virtual-instruction (cause 22) in supervisor mode with `virt_on` at 1. It asserts `flush_req` in machine mode (3), or in supervisor mode with `virt_on` at 0. In every other case it raises illegal-instruction (cause 2).
- R7: A guest-physical hypervisor fence (op 3) in supervisor mode with `virt_on` at 0 and `tvm_bit` at 1 raises illegal-instruction (cause 2). This check comes before R6.
- R8: The outcome appears on the cycle after `req_valid` and lasts one cycle. Exactly one of `halt_req`, `flush_req` and `exc_valid` is 1 for each request. All three are 0 on a cycle that follows no request, and `exc_cause` is 0 whenever `exc_valid` is 0.
- R9: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request pulse |
| req_op | input | 2 | 0 wait-for-interrupt, 1 supervisor fence, 2 guest-virtual fence, 3 guest-physical fence |
| cur_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virt_on | input | 1 | Core is running a guest |
| has_smode | input | 1 | Supervisor mode is implemented |
| has_hyp | input | 1 | Hypervisor is implemented |
| tw_bit | input | 1 | Trap wait-for-interrupt below machine mode |
| tvm_bit | input | 1 | Trap translation management in supervisor mode |
| vtw_bit | input | 1 | Guest wait-for-interrupt trap |
| vtvm_bit | input | 1 | Guest translation management trap |
| halt_req | output | 1 | Stall for interrupt |
| flush_req | output | 1 | Flush the translation cache |
| exc_valid | output | 1 | Exception strobe |
| exc_cause | output | CAUSE_W | Exception cause code (2 or 22) |

## Verification
The hardest cases to reach are the priority overlaps. One is a virtualized supervisor-mode wait-for-interrupt where both `tw_bit` and `vtw_bit` are 1: the illegal-instruction result must win. Another is a guest-physical fence where the R7 check comes before R6. A third is a supervisor fence with `tvm_bit` and `vtvm_bit` both set. Directed requests set each of these combinations explicitly. Several thousand random requests then draw every input from `$urandom` with a fixed seed. Those requests come with random idle gaps, so every privilege, mode and flag combination is reached many times and the idle-cycle rule is exercised as well.

// File: rtl/priv_trap_gate.sv
module priv_trap_gate #(
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] ILL_CAUSE  = CAUSE_W'(2),
  parameter logic [CAUSE_W-1:0] VIRT_CAUSE = CAUSE_W'(22)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [1:0]         cur_priv,
  input  logic               virt_on,
  input  logic               has_smode,
  input  logic               has_hyp,
  input  logic               tw_bit,
  input  logic               tvm_bit,
  input  logic               vtw_bit,
  input  logic               vtvm_bit,
  output logic               halt_req,
  output logic               flush_req,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause
);
  localparam logic [1:0] OP_WFI   = 2'd0;
  localparam logic [1:0] OP_SFENCE = 2'd1;
  localparam logic [1:0] OP_HVVMA = 2'd2;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  wire is_u = cur_priv == PRV_U;
  wire is_s = cur_priv == PRV_S;
  wire is_m = cur_priv == PRV_M;

  wire wfi_ill  = (tw_bit && (is_s || (is_u && !has_smode))) || (has_smode && is_u && !virt_on);
  wire wfi_virt = virt_on && (is_u || (is_s && vtw_bit));
  wire sf_ill   = is_u || (is_s && tvm_bit);
  wire sf_virt  = has_hyp && virt_on && vtvm_bit;
  wire hf_virt  = is_s && virt_on;
  wire hf_go    = is_m || (is_s && !virt_on);
  wire gv_pre   = is_s && !virt_on && tvm_bit;

  logic d_ill, d_virt, d_halt, d_flush;

  always_comb begin
    d_ill = 1'b0; d_virt = 1'b0; d_halt = 1'b0; d_flush = 1'b0;
    if (req_op == OP_WFI) begin
      if (wfi_ill)       d_ill  = 1'b1;
      else if (wfi_virt) d_virt = 1'b1;
      else               d_halt = 1'b1;
    end else if (req_op == OP_SFENCE) begin
      if (sf_ill)        d_ill   = 1'b1;
      else if (sf_virt)  d_virt  = 1'b1;
      else               d_flush = 1'b1;
    end else begin
      if (req_op != OP_HVVMA && gv_pre) d_ill   = 1'b1;
      else if (hf_virt)                 d_virt  = 1'b1;
      else if (hf_go)                   d_flush = 1'b1;
      else                              d_ill   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_req  <= 1'b0;
      flush_req <= 1'b0;
      exc_valid <= 1'b0;
      exc_cause <= '0;
    end else begin
      halt_req  <= req_valid && d_halt;
      flush_req <= req_valid && d_flush;
      exc_valid <= req_valid && (d_ill || d_virt);
      exc_cause <= !req_valid ? '0 : d_ill ? ILL_CAUSE : d_virt ? VIRT_CAUSE : '0;
    end
  end

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({halt_req, flush_req, exc_valid}) == 1);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !halt_req && !flush_req && !exc_valid && exc_cause == '0);
  a_r8_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_cause == ILL_CAUSE || exc_cause == VIRT_CAUSE));
  a_r4_halt_only_wfi: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op != OP_WFI |=> !halt_req);
  a_r6_user_hfence_ill: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op[1] && is_u |=> exc_valid && exc_cause == ILL_CAUSE);
  a_r5_user_sfence_ill: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == OP_SFENCE && is_u |=> exc_valid && exc_cause == ILL_CAUSE);
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !halt_req && !flush_req && !exc_valid);
endmodule

// File: tb/tb_priv_trap_gate.sv
`timescale 1ns/1ps
module tb_priv_trap_gate;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [1:0] req_op = '0, cur_priv = '0;
  logic virt_on = 0, has_smode = 0, has_hyp = 0, tw_bit = 0, tvm_bit = 0, vtw_bit = 0, vtvm_bit = 0;
  logic halt_req, flush_req, exc_valid;
  logic [4:0] exc_cause;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  priv_trap_gate dut (.*);

  // 0 halt, 1 flush, 2 illegal, 3 virtual
  function automatic int expect_kind(input logic [1:0] op, input logic [1:0] p,
      input logic v, input logic hs, input logic hh, input logic tw, input logic tvm,
      input logic vtw, input logic vtvm);
    case (op)
      2'd0: begin
        if ((tw && (p == 1 || (p == 0 && !hs))) || (hs && p == 0 && !v)) return 2;
        if (v && (p == 0 || (p == 1 && vtw))) return 3;
        return 0;
      end
      2'd1: begin
        if (p == 0 || (p == 1 && tvm)) return 2;
        if (hh && v && vtvm) return 3;
        return 1;
      end
      default: begin
        if (op == 2'd3 && p == 1 && !v && tvm) return 2;
        if (p == 1 && v) return 3;
        if (p == 3 || (p == 1 && !v)) return 1;
        return 2;
      end
    endcase
  endfunction

  function automatic string req_tag(input logic [1:0] op, input logic [1:0] p,
      input logic v, input logic hs, input logic tw, input logic tvm, input int k);
    if (op == 2'd0) begin
      if (k == 2) return (tw && (p == 1 || (p == 0 && !hs))) ? "R1" : "R2";
      return k == 3 ? "R3" : "R4";
    end
    if (op == 2'd1) return "R5";
    if (op == 2'd3 && p == 1 && !v && tvm) return "R7";
    return "R6";
  endfunction

  task automatic check_out(input string tag, input logic h, input logic f, input logic e, input logic [4:0] c);
    checks++;
    if (halt_req !== h || flush_req !== f || exc_valid !== e || exc_cause !== c) begin
      failures++;
      $display("FAIL %s: got halt=%b flush=%b exc=%b cause=%0d expected halt=%b flush=%b exc=%b cause=%0d",
               tag, halt_req, flush_req, exc_valid, exc_cause, h, f, e, c);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] p, input logic v, input logic hs,
      input logic hh, input logic tw, input logic tvm, input logic vtw, input logic vtvm, input int gap);
    int k;
    req_valid = 1; req_op = op; cur_priv = p; virt_on = v; has_smode = hs; has_hyp = hh;
    tw_bit = tw; tvm_bit = tvm; vtw_bit = vtw; vtvm_bit = vtvm;
    k = expect_kind(op, p, v, hs, hh, tw, tvm, vtw, vtvm);
    @(negedge clk);
    req_valid = 0;
    req_op = 2'($urandom); cur_priv = 2'($urandom); tw_bit = 1'($urandom);
    check_out(req_tag(op, p, v, hs, tw, tvm, k), k == 0, k == 1, k >= 2,
              k == 2 ? 5'd2 : k == 3 ? 5'd22 : 5'd0);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check_out("R8", 0, 0, 0, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    req_valid = 1;
    repeat (3) @(negedge clk);
    check_out("R9", 0, 0, 0, 0);
    rst_n = 1; req_valid = 0;
    @(negedge clk);
    check_out("R8", 0, 0, 0, 0);
    // directed corners
    send(0, 1, 0, 1, 1, 1, 0, 0, 0, 0); // R1 S with TW
    send(0, 0, 0, 0, 0, 1, 0, 0, 0, 0); // R1 U without S mode
    send(0, 0, 0, 1, 1, 0, 0, 0, 0, 1); // R2
    send(0, 1, 1, 1, 1, 1, 0, 1, 0, 0); // R1 precedence over R3
    send(0, 1, 1, 1, 1, 0, 0, 1, 0, 0); // R3 S with VTW
    send(0, 0, 1, 1, 1, 0, 0, 0, 0, 0); // R3 virtual U
    send(0, 3, 0, 1, 1, 1, 1, 1, 1, 0); // R4 machine
    send(0, 0, 0, 0, 0, 0, 0, 0, 0, 2); // R4 U-only core
    send(1, 1, 1, 1, 1, 0, 1, 0, 1, 0); // R5 TVM beats VTVM
    send(1, 1, 1, 1, 1, 0, 0, 0, 1, 0); // R5 virtual
    send(1, 1, 1, 1, 0, 0, 0, 0, 1, 0); // R5 no hyp -> flush
    send(1, 3, 0, 1, 1, 0, 1, 0, 0, 0); // R5 machine flush
    send(2, 1, 1, 1, 1, 0, 0, 0, 0, 0); // R6 virtual S
    send(2, 1, 0, 1, 1, 0, 1, 0, 0, 0); // R6 VVMA ignores TVM
    send(2, 0, 1, 1, 1, 0, 0, 0, 0, 0); // R6 virtual U illegal
    send(3, 1, 0, 1, 1, 0, 1, 0, 0, 0); // R7
    send(3, 1, 1, 1, 1, 0, 1, 0, 0, 0); // R6 virtual S with TVM
    send(3, 3, 0, 1, 1, 0, 1, 0, 0, 0); // R6 machine flush
    for (int n = 0; n < 4000; n++)
      send(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 2)));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule